// File: doc/BRIEF.md
# Bridge Window Configuration Register File

This block is the software-visible setup store of a host bridge. Software reaches it through a 32-bit register bus: a write strobe, a read strobe and a register index. It keeps a base and a mask for six address windows: configuration, message, three outbound windows and the bridge's own register window. It also keeps two plain 32-bit words, a special word and a control word.

From the stored masks it computes, for every window, an enable bit and a byte size. These drive the address decoders next to it. Each instance answers to a block of 23 consecutive indices that starts at a base index chosen by a parameter. A chip places two instances, one at each of the two legal bases.

Bases and outbound masks are 64 bits wide. Software loads them one 32-bit half at a time, so a half write never disturbs the other half. Window size is the two's complement of the mask with bit 0 cleared, and bit 0 is the enable.

Top module: `bwin_regfile`

## Requirements
- R1: Offsets from the base index map as follows, and a read of any of the 23 offsets returns the last 32-bit value written there. Configuration window: base high 0, base low 1, mask 2. Message window: 3, 4, 5. Outbound window n (n = 1..3): base high 6+4(n-1), base low 7+4(n-1), mask high 8+4(n-1), mask low 9+4(n-1). Register window: base high 18, base low 19, mask 20. Special word 21. Control word 22.
- R2: A write to a high half replaces bits [63:32] of the stored 64-bit value and keeps bits [31:0]. A write to a low half replaces bits [31:0] and keeps bits [63:32]. A high-half read returns bits [63:32] and a low-half read returns bits [31:0].
- R3: A window's enable on win_en_o[w] equals bit 0 of its mask. Window numbers are: 0 configuration, 1 message, 2 to 4 outbound 1 to 3, 5 register.
- R4: win_size_o[64w+63:64w] equals the two's complement of the mask with bit 0 cleared. For outbound windows this is taken over all 64 bits. For the other windows it is taken over 32 bits and then zero-extended, so a mask of zero gives size zero.
- R5: For the register window only, a mask of 0x00007001 gives a size of 4096. Every other mask follows R4.
- R6: A read at an index outside the 23-register range gives rdata_o = 0. A write there changes no stored register and no output.
- R7: Reset clears every register. After reset every read returns 0, every enable is 0 and every size is 0.
- R8: Enable and size outputs take their new values on the same clock edge that accepts the mask write. They stay unchanged on cycles without a write.
- R9: Read data is registered: rdata_o shows the value one clock after rd_i and holds it until the next read. A read and a write to the same index in one cycle return the value from before the write.
- R10: Decoding is relative to BASE_IDX, which must be 0x100 or 0x120; any other value stops elaboration. An instance at 0x120 ignores indices 0x100 to 0x116.
- R11: Each outbound window's mask-high and mask-low offsets read back that window's own stored mask halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| idx_i | input | IDX_W | Register index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| win_en_o | output | 6 | Per-window enable |
| win_size_o | output | 384 | Per-window size, 64 bits per window |

## Verification
The assertions check on every cycle the properties that can be stated locally. Out-of-range reads return zero, and out-of-range or idle cycles leave every window output stable. The configuration enable follows bit 0 of the mask write, and the 0x7001 register-window case gives 4096. A read issued straight after a write to the same index returns the written data, and outputs are zero while reset is held. The bench scenarios are needed for the rest. They sweep every offset for read-back, prove half-word preservation, and walk all mask widths against arithmetically computed sizes. They also show the exact edge at which the outputs change and that a read in the same cycle as a write returns the old value.

// File: rtl/bwin_pkg.sv
package bwin_pkg;
  localparam int unsigned NUM_OFS = 23;
  localparam int unsigned NUM_WIN = 6;
  localparam int unsigned OFS_W   = $clog2(NUM_OFS);
  localparam int unsigned OFS_SPEC = 21;
  localparam int unsigned OFS_CTRL = 22;
  localparam int unsigned WIN_REG  = 5;

  typedef struct packed {
    logic [NUM_WIN-1:0] base_hi;
    logic [NUM_WIN-1:0] base_lo;
    logic [NUM_WIN-1:0] mask_hi;
    logic [NUM_WIN-1:0] mask_lo;
    logic               spec;
    logic               ctrl;
  } wsel_t;

  // first offset of each window group
  function automatic int unsigned win_ofs(int unsigned w);
    case (w)
      0: return 0;
      1: return 3;
      2: return 6;
      3: return 10;
      4: return 14;
      default: return 18;
    endcase
  endfunction

  // outbound windows carry a 64-bit mask
  function automatic bit win_wide(int unsigned w);
    return (w >= 2) && (w <= 4);
  endfunction
endpackage

// File: rtl/bwin_idx_dec.sv
module bwin_idx_dec import bwin_pkg::*; #(
  parameter int unsigned IDX_W    = 10,
  parameter int unsigned BASE_IDX = 'h100
) (
  input  logic [IDX_W-1:0] idx_i,
  output wsel_t            sel_o
);
  localparam logic [IDX_W-1:0] BASE = IDX_W'(BASE_IDX);

  logic [IDX_W-1:0] rel;
  logic             hit;
  logic [OFS_W-1:0] ofs;

  assign rel = idx_i - BASE;
  assign hit = (idx_i >= BASE) && (rel < IDX_W'(NUM_OFS));
  assign ofs = rel[OFS_W-1:0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam int unsigned S = win_ofs(w);
    assign sel_o.base_hi[w] = hit && (ofs == OFS_W'(S));
    assign sel_o.base_lo[w] = hit && (ofs == OFS_W'(S + 1));
    if (win_wide(w)) begin : g_wide
      assign sel_o.mask_hi[w] = hit && (ofs == OFS_W'(S + 2));
      assign sel_o.mask_lo[w] = hit && (ofs == OFS_W'(S + 3));
    end else begin : g_narrow
      assign sel_o.mask_hi[w] = 1'b0;
      assign sel_o.mask_lo[w] = hit && (ofs == OFS_W'(S + 2));
    end
  end

  assign sel_o.spec = hit && (ofs == OFS_W'(OFS_SPEC));
  assign sel_o.ctrl = hit && (ofs == OFS_W'(OFS_CTRL));
endmodule

// File: rtl/bwin_half_reg.sv
module bwin_half_reg (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        hi_we_i,
  input  logic        lo_we_i,
  input  logic [31:0] wdata_i,
  output logic [63:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else begin
      if (hi_we_i) q_o[63:32] <= wdata_i;
      if (lo_we_i) q_o[31:0]  <= wdata_i;
    end
  end
endmodule

// File: rtl/bwin_size_calc.sv
module bwin_size_calc #(
  parameter bit          WIDE       = 1'b0,
  parameter bit          QUIRK_EN   = 1'b0,
  parameter logic [31:0] QUIRK_MASK = 32'h0000_7001,
  parameter logic [63:0] QUIRK_SIZE = 64'd4096
) (
  input  logic [63:0] mask_i,
  output logic        en_o,
  output logic [63:0] size_o
);
  logic [63:0] raw;

  assign en_o = mask_i[0];

  if (WIDE) begin : g_wide
    assign raw = ~(mask_i & ~64'h1) + 64'h1;
  end else begin : g_narrow
    logic [31:0] m32;
    logic        unused_hi;
    assign unused_hi = ^mask_i[63:32];
    assign m32 = mask_i[31:0] & ~32'h1;
    assign raw = {32'h0, ~m32 + 32'h1};
  end

  if (QUIRK_EN) begin : g_quirk
    assign size_o = (mask_i[31:0] == QUIRK_MASK) ? QUIRK_SIZE : raw;
  end else begin : g_plain
    assign size_o = raw;
  end
endmodule

// File: rtl/bwin_regfile.sv
module bwin_regfile import bwin_pkg::*; #(
  parameter int unsigned IDX_W    = 10,
  parameter int unsigned BASE_IDX = 'h100
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic                   rd_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [31:0]            wdata_i,
  output logic [31:0]            rdata_o,
  output logic [NUM_WIN-1:0]     win_en_o,
  output logic [NUM_WIN*64-1:0]  win_size_o
);
  if (BASE_IDX != 'h100 && BASE_IDX != 'h120) begin : g_bad_base
    $error("bwin_regfile: BASE_IDX must be 0x100 or 0x120");
  end

  wsel_t       sel;
  logic [63:0] base_q [NUM_WIN];
  logic [63:0] mask_q [NUM_WIN];
  logic [31:0] spec_q, ctrl_q, rd_val, rdata_q;

  bwin_idx_dec #(.IDX_W(IDX_W), .BASE_IDX(BASE_IDX)) u_dec (
    .idx_i (idx_i),
    .sel_o (sel)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    bwin_half_reg u_base (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .hi_we_i (wr_i && sel.base_hi[w]),
      .lo_we_i (wr_i && sel.base_lo[w]),
      .wdata_i (wdata_i),
      .q_o     (base_q[w])
    );
    bwin_half_reg u_mask (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .hi_we_i (wr_i && sel.mask_hi[w]),
      .lo_we_i (wr_i && sel.mask_lo[w]),
      .wdata_i (wdata_i),
      .q_o     (mask_q[w])
    );
    bwin_size_calc #(
      .WIDE     (win_wide(w)),
      .QUIRK_EN (w == WIN_REG)
    ) u_size (
      .mask_i (mask_q[w]),
      .en_o   (win_en_o[w]),
      .size_o (win_size_o[w*64 +: 64])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spec_q <= '0;
      ctrl_q <= '0;
    end else if (wr_i) begin
      if (sel.spec) spec_q <= wdata_i;
      if (sel.ctrl) ctrl_q <= wdata_i;
    end
  end

  // selects are one-hot or zero, so an OR tree forms the mux
  always_comb begin
    rd_val = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (sel.base_hi[w]) rd_val |= base_q[w][63:32];
      if (sel.base_lo[w]) rd_val |= base_q[w][31:0];
      if (sel.mask_hi[w]) rd_val |= mask_q[w][63:32];
      if (sel.mask_lo[w]) rd_val |= mask_q[w][31:0];
    end
    if (sel.spec) rd_val |= spec_q;
    if (sel.ctrl) rd_val |= ctrl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/bwin_regfile_chk.sv
module bwin_regfile_chk #(
  parameter int unsigned IDX_W    = 10,
  parameter int unsigned BASE_IDX = 'h100
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_i,
  input logic               rd_i,
  input logic [IDX_W-1:0]   idx_i,
  input logic [31:0]        wdata_i,
  input logic [31:0]        rdata_o,
  input logic [5:0]         win_en_o,
  input logic [383:0]       win_size_o
);
  localparam logic [IDX_W-1:0] B = IDX_W'(BASE_IDX);

  logic in_rng;
  assign in_rng = (idx_i >= B) && ((idx_i - B) < IDX_W'(23));

  // R6
  oob_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !in_rng) |=> (rdata_o == 32'h0));

  // R6
  oob_write_inert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !in_rng) |=> ($stable(win_size_o) && $stable(win_en_o)));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(win_size_o) && $stable(win_en_o)));

  // R3
  cfg_en_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == B + IDX_W'(2)) |=> (win_en_o[0] == $past(wdata_i[0])));

  // R5
  reg_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == B + IDX_W'(20) && wdata_i == 32'h0000_7001)
      |=> (win_size_o[5*64 +: 64] == 64'd4096));

  // R9
  rd_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && in_rng && $past(wr_i) && idx_i == $past(idx_i))
      |=> (rdata_o == $past(wdata_i, 2)));

  // R7
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_clear_chk: assert (win_en_o == '0 && win_size_o == '0 && rdata_o == '0);
    end
  end
endmodule

bind bwin_regfile bwin_regfile_chk #(.IDX_W(IDX_W), .BASE_IDX(BASE_IDX)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .idx_i      (idx_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .win_en_o   (win_en_o),
  .win_size_o (win_size_o)
);

// File: tb/sim_bwin_regfile.sv
`timescale 1ns/1ps
module sim_bwin_regfile;
  localparam int unsigned IW = 10;
  localparam logic [9:0]  B  = 10'h120;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr = 1'b0, rd = 1'b0;
  logic [9:0]   idx = '0;
  logic [31:0]  wd = '0;
  logic [31:0]  rdata;
  logic [5:0]   en;
  logic [383:0] size;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] shadow [23];

  always #2.5 clk = ~clk;

  bwin_regfile #(.IDX_W(IW), .BASE_IDX('h120)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .idx_i(idx),
    .wdata_i(wd), .rdata_o(rdata), .win_en_o(en), .win_size_o(size)
  );

  function automatic int st(int w);
    case (w) 0: return 0; 1: return 3; 2: return 6; 3: return 10; 4: return 14; default: return 18; endcase
  endfunction

  function automatic logic [63:0] exp_mask(int w);
    if (w >= 2 && w <= 4) return {shadow[st(w)+2], shadow[st(w)+3]};
    return {32'h0, shadow[st(w)+2]};
  endfunction

  function automatic logic [63:0] exp_size(int w);
    logic [63:0] m;
    logic [31:0] n;
    m = exp_mask(w);
    if (w >= 2 && w <= 4) return 64'h0 - (m & ~64'h1);
    if (w == 5 && m[31:0] == 32'h7001) return 64'd4096;
    n = 32'h0 - (m[31:0] & ~32'h1);
    return {32'h0, n};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic chk_win(input string tag);
    for (int w = 0; w < 6; w++) begin
      chk(tag, {63'h0, en[w]}, {63'h0, exp_mask(w) & 64'h1});
      chk(tag, size[w*64 +: 64], exp_size(w));
    end
  endtask

  task automatic do_wr(input logic [9:0] i, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; idx = i; wd = d;
    @(negedge clk); wr = 1'b0;
    if (i >= B && i < B + 10'd23) shadow[i - B] = d;
  endtask

  task automatic do_rd(input logic [9:0] i, output logic [31:0] v);
    @(negedge clk); rd = 1'b1; idx = i;
    @(negedge clk); rd = 1'b0; v = rdata;
  endtask

  task automatic read_all(input string tag);
    logic [31:0] v;
    for (int o = 0; o < 23; o++) begin
      do_rd(B + 10'(o), v);
      chk(tag, {32'h0, v}, {32'h0, shadow[o]});
    end
  endtask

  initial begin
    logic [31:0] v, old;
    for (int o = 0; o < 23; o++) shadow[o] = '0;
    repeat (3) @(negedge clk);
    chk("R7 en at reset", {58'h0, en}, 64'h0);
    chk("R7 size at reset", {63'h0, |size}, 64'h0);
    rst_n = 1'b1;
    read_all("R7 reset readback");
    chk_win("R7 windows idle");

    // R1 / R11: distinct pattern in every offset
    for (int o = 0; o < 23; o++) begin
      do_wr(B + 10'(o), {8'(o), ~8'(o), 8'h5A ^ 8'(o), 8'(3*o)});
      chk_win("R4 after fill write");
    end
    read_all("R1 R11 readback");

    // R2: half preservation on a base and an outbound mask
    do_wr(B + 10'd10, 32'hDEAD_BEEF);
    do_rd(B + 10'd11, v); chk("R2 base low kept", {32'h0, v}, {32'h0, shadow[11]});
    do_rd(B + 10'd10, v); chk("R2 base high new", {32'h0, v}, 64'h0000_0000_DEAD_BEEF);
    do_wr(B + 10'd17, 32'h0000_1001);
    do_rd(B + 10'd16, v); chk("R2 mask high kept", {32'h0, v}, {32'h0, shadow[16]});
    chk_win("R2 R4 ob3 size");

    // R4 sweep: narrow windows
    for (int k = 1; k < 32; k++) begin
      do_wr(B + 10'd2, ~((32'h1 << k) - 32'h1) | 32'h1);
      chk("R4 cfg size", size[0 +: 64], 64'h1 << k);
      chk("R3 cfg en", {63'h0, en[0]}, 64'h1);
      do_wr(B + 10'd5, ~((32'h1 << k) - 32'h1));
      chk("R3 msg en off", {63'h0, en[1]}, 64'h0);
      chk_win("R4 msg sweep");
    end
    do_wr(B + 10'd2, 32'h0);
    chk("R4 zero mask size", size[0 +: 64], 64'h0);

    // R4 sweep: 64-bit outbound masks
    for (int k = 1; k < 64; k++) begin
      logic [63:0] m;
      m = ~((64'h1 << k) - 64'h1) | 64'h1;
      do_wr(B + 10'd8, m[63:32]);
      do_wr(B + 10'd9, m[31:0]);
      chk("R4 ob1 size", size[2*64 +: 64], 64'h1 << k);
      chk_win("R4 ob sweep");
    end

    // R5: register window quirk and neighbours
    do_wr(B + 10'd20, 32'h0000_7001);
    chk("R5 quirk size", size[5*64 +: 64], 64'd4096);
    chk("R5 quirk en", {63'h0, en[5]}, 64'h1);
    do_wr(B + 10'd20, 32'h0000_7000);
    chk("R5 neighbour size", size[5*64 +: 64], 64'h0000_0000_FFFF_9000);
    do_wr(B + 10'd20, 32'hFFFF_F001);
    chk("R5 normal size", size[5*64 +: 64], 64'h1000);
    do_wr(B + 10'd2, 32'h0000_7001);
    chk("R5 cfg not quirked", size[0 +: 64], 64'h0000_0000_FFFF_9000);

    // R6 / R10: indices outside this instance
    do_wr(B - 10'd1, 32'hFFFF_FFFF);
    do_wr(B + 10'd23, 32'hFFFF_FFFF);
    do_wr(10'h3FF, 32'hFFFF_FFFF);
    for (int o = 0; o < 23; o++) do_wr(10'h100 + 10'(o), 32'hFFFF_FFFF);
    chk_win("R6 R10 outputs unchanged");
    read_all("R6 R10 state unchanged");
    do_rd(B - 10'd1, v);  chk("R6 oob read", {32'h0, v}, 64'h0);
    do_rd(B + 10'd23, v); chk("R6 oob read", {32'h0, v}, 64'h0);
    do_rd(10'h102, v);    chk("R10 other base read", {32'h0, v}, 64'h0);

    // R8: change lands on the accepting edge
    do_wr(B + 10'd2, 32'h0);
    @(negedge clk); wr = 1'b1; idx = B + 10'd2; wd = 32'hFFFF_0001;
    #1.0;
    chk("R8 before edge", {63'h0, en[0]}, 64'h0);
    @(posedge clk); #0.5;
    chk("R8 after edge en", {63'h0, en[0]}, 64'h1);
    chk("R8 after edge size", size[0 +: 64], 64'h1_0000);
    @(negedge clk); wr = 1'b0; shadow[2] = 32'hFFFF_0001;

    // R9: read in the write cycle returns the old value
    old = shadow[21];
    @(negedge clk); wr = 1'b1; rd = 1'b1; idx = B + 10'd21; wd = 32'h1234_5678;
    @(negedge clk); wr = 1'b0; rd = 1'b0;
    chk("R9 same-cycle old value", {32'h0, rdata}, {32'h0, old});
    shadow[21] = 32'h1234_5678;
    repeat (2) @(negedge clk);
    chk("R9 data held", {32'h0, rdata}, {32'h0, old});
    do_rd(B + 10'd21, v); chk("R9 new value", {32'h0, v}, 64'h1234_5678);
    read_all("R1 final readback");

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule